// File: doc/BRIEF.md
# Quad GPIO with Poll-Answered Change Reporting

This block is a four-pin general-purpose I/O peripheral on a byte-wide, strobe/acknowledge register bus. Software configures a per-pin direction, a stored output value and a single enable for change reporting. Each output pin drives its stored value and asserts its output enable. Each input pin is sampled through a two-flop synchronizer, and its state can be read back.

The block has no interrupt line. A bus controller polls it at intervals. When reporting is enabled and a pin configured as an input has changed, the block marks a report as pending. The next poll then answers with a nonzero byte count, which equals the number of mapped registers. The controller uses that count to read the registers in order from address 0 and forward them upstream. A poll that finds nothing pending answers 0. A poll that answers nonzero clears the pending mark.

Top module: `quad_gpio`

## Requirements
- R1: After a synchronous active-high reset, the value, direction and report-enable registers are 0. pin_oe and pin_out are 0 and bus_ack is low.
- R2: Register 0 is the pin value, register 1 is the direction (bit n = 1 makes pin n an output) and register 2 holds the report enable in bit 0. These registers are written at consecutive addresses, and a read returns each register in bits [3:0] (bit 0 only for register 2), with all higher bits 0.
- R3: Every cycle in which bus_stb is high is answered by bus_ack high in the following cycle. bus_ack is low in the cycle after a cycle without a strobe.
- R4: A read of an address above 2 returns 0. A write to such an address changes no register and no pin output.
- R5: pin_oe equals the direction register. pin_out carries the stored value on output pins and 0 on input pins.
- R6: A read of register 0 returns the stored value for output pins and the synchronized input level for input pins.
- R7: A poll (bus_stb with bus_poll high) returns 3 when a report is pending and 0 when none is. A report becomes pending once a change on an input pin has passed the synchronizer while the enable is 1.
- R8: A poll that returns a nonzero count clears the pending report, so an immediate second poll returns 0.
- R9: Changes on pins configured as outputs, and any change while the report enable is 0, never make a report pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read (ignored on poll) |
| bus_poll | input | 1 | Marks the access as a poll for a byte count |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or poll byte count, valid with bus_ack |
| bus_ack | output | 1 | Acknowledge, one cycle after the strobe |
| pin_in | input | 4 | Raw asynchronous pin levels |
| pin_out | output | 4 | Driven pin levels |
| pin_oe | output | 4 | Per-pin output enable |

## Verification
A bus result appears one cycle after its strobe: bus_ack and bus_rdata are registered at the edge that samples the strobe. Register writes reach pin_oe and pin_out at that same edge. A pin change needs two edges to reach the read-back path and a third to become a pending report. The bench drives every input on the falling edge and samples on the falling edge after the edge at which the result is due. It waits three cycles after a pin change before a read and four before a poll, so each check lands in the cycle its result is due.

// File: rtl/quad_gpio_pkg.sv
package quad_gpio_pkg;

    localparam int NUM_PINS  = 4;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int SYNC_LEN  = 2;
    localparam int NUM_REGS  = 3;

    // register selector; the ordering matters because the controller
    // forwards registers upward starting at index 0
    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'd0,
        SEL_DIR    = 2'd1,
        SEL_REPORT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_PINS-1:0] level;
        logic [NUM_PINS-1:0] dir;
        logic                report_en;
    } gpio_cfg_t;

    function automatic logic [DATA_W-1:0] widen(input logic [NUM_PINS-1:0] v);
        return {{(DATA_W-NUM_PINS){1'b0}}, v};
    endfunction

    function automatic logic [NUM_PINS-1:0] blend(
        input logic [NUM_PINS-1:0] stored,
        input logic [NUM_PINS-1:0] dir,
        input logic [NUM_PINS-1:0] sampled
    );
        return (stored & dir) | (sampled & ~dir);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import quad_gpio_pkg::*;
#(
    parameter int WIDTH  = NUM_PINS,
    parameter int STAGES = SYNC_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    localparam int LAST = STAGES - 1;

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], raw[p]};
        end
        assign synced[p] = chain[LAST];
    end

endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det
    import quad_gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] synced,
    input  logic [NUM_PINS-1:0] dir,
    input  logic                report_en,
    input  logic                poll_clear,
    output logic                pending
);
    logic [NUM_PINS-1:0] prev;
    logic [NUM_PINS-1:0] moved;
    logic                raise;

    assign moved = (synced ^ prev) & ~dir;
    assign raise = report_en & (|moved);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            pending <= 1'b0;
        end else begin
            prev    <= synced;
            pending <= (pending & ~poll_clear) | raise;
        end
    end

    a_r7_change_latches: assert property (@(posedge clk) disable iff (rst)
        raise |=> pending);
    a_r8_poll_clears: assert property (@(posedge clk) disable iff (rst)
        (poll_clear && !raise) |=> !pending);
    a_r9_silent_when_off: assert property (@(posedge clk) disable iff (rst)
        (!report_en && !pending) |=> !pending);
    a_r9_outputs_silent: assert property (@(posedge clk) disable iff (rst)
        ((&dir) && !pending) |=> !pending);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import quad_gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_stb,
    input  logic                bus_we,
    input  logic                bus_poll,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    input  logic [NUM_PINS-1:0] synced,
    input  logic                pending,
    output logic                poll_clear,
    output gpio_cfg_t           cfg
);
    localparam logic [DATA_W-1:0] COUNT = DATA_W'(NUM_REGS);

    logic                mapped;
    reg_sel_e            sel;
    logic [DATA_W-1:0]   read_word;
    logic [DATA_W-NUM_PINS-1:0] unused_wdata_hi;

    assign unused_wdata_hi = bus_wdata[DATA_W-1:NUM_PINS];
    assign mapped     = bus_addr < ADDR_W'(NUM_REGS);
    assign sel        = reg_sel_e'(bus_addr[1:0]);
    assign poll_clear = bus_stb & bus_poll & pending;

    always_comb begin
        read_word = '0;
        if (mapped) begin
            case (sel)
                SEL_LEVEL:  read_word = widen(blend(cfg.level, cfg.dir, synced));
                SEL_DIR:    read_word = widen(cfg.dir);
                SEL_REPORT: read_word = {{(DATA_W-1){1'b0}}, cfg.report_en};
                default:    read_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_stb;
            bus_rdata <= '0;
            if (bus_stb) begin
                if (bus_poll) begin
                    bus_rdata <= pending ? COUNT : '0;
                end else if (bus_we) begin
                    if (mapped) begin
                        case (sel)
                            SEL_LEVEL:  cfg.level     <= bus_wdata[NUM_PINS-1:0];
                            SEL_DIR:    cfg.dir       <= bus_wdata[NUM_PINS-1:0];
                            SEL_REPORT: cfg.report_en <= bus_wdata[0];
                            default:    ;
                        endcase
                    end
                end else begin
                    bus_rdata <= read_word;
                end
            end
        end
    end

    a_r3_ack_follows_stb: assert property (@(posedge clk) disable iff (rst)
        bus_stb |=> bus_ack);
    a_r3_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !bus_stb |=> !bus_ack);
    a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0));
    a_r7_count_values: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_poll) |=> (bus_rdata == '0 || bus_rdata == COUNT));
    a_r4_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_poll && !bus_we && !mapped) |=> (bus_rdata == '0));

endmodule

// File: rtl/quad_gpio.sv
module quad_gpio
    import quad_gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_stb,
    input  logic                bus_we,
    input  logic                bus_poll,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic [NUM_PINS-1:0] synced;
    logic                pending;
    logic                poll_clear;
    gpio_cfg_t           cfg;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .synced (synced)
    );

    gpio_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_stb    (bus_stb),
        .bus_we     (bus_we),
        .bus_poll   (bus_poll),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .synced     (synced),
        .pending    (pending),
        .poll_clear (poll_clear),
        .cfg        (cfg)
    );

    gpio_change_det u_det (
        .clk        (clk),
        .rst        (rst),
        .synced     (synced),
        .dir        (cfg.dir),
        .report_en  (cfg.report_en),
        .poll_clear (poll_clear),
        .pending    (pending)
    );

    assign pin_oe  = cfg.dir;
    assign pin_out = cfg.level & cfg.dir;

    a_r5_dir_write_reaches_oe: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_we && !bus_poll && bus_addr == ADDR_W'(1))
            |=> (pin_oe == $past(bus_wdata[NUM_PINS-1:0])));
    a_r4_unmapped_write_inert: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_we && !bus_poll && bus_addr >= ADDR_W'(NUM_REGS))
            |=> ($stable(pin_oe) && $stable(pin_out)));
    a_r5_inputs_not_driven: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

endmodule

// File: tb/quad_gpio_bench.sv
module quad_gpio_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_stb = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_poll = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_ack;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    quad_gpio u_quad_gpio (
        .clk       (clk),
        .rst       (rst),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_poll  (bus_poll),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access: strobe for one cycle, result sampled one cycle later
    task automatic access(input logic poll, input logic we, input logic [7:0] addr,
                          input logic [7:0] wdata, output logic [7:0] rd);
        @(negedge clk);
        bus_stb = 1'b1; bus_poll = poll; bus_we = we;
        bus_addr = addr; bus_wdata = wdata;
        @(negedge clk);
        chk("R3 ack after strobe", {7'd0, bus_ack}, 8'd1);
        rd = bus_rdata;
        bus_stb = 1'b0; bus_poll = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] d);
        logic [7:0] rd;
        access(1'b0, 1'b1, addr, d, rd);
    endtask

    task automatic rdreg(input logic [7:0] addr, output logic [7:0] d);
        access(1'b0, 1'b0, addr, 8'h00, d);
    endtask

    task automatic poll(output logic [7:0] d);
        access(1'b1, 1'b0, 8'h00, 8'h00, d);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 ack low", {7'd0, bus_ack}, 8'd0);
        chk("R1 oe zero", {4'd0, pin_oe}, 8'd0);
        chk("R1 out zero", {4'd0, pin_out}, 8'd0);
        rdreg(8'd0, d); chk("R1 level reg", d, 8'h00);
        rdreg(8'd1, d); chk("R1 dir reg", d, 8'h00);
        rdreg(8'd2, d); chk("R1 report reg", d, 8'h00);
        poll(d);        chk("R1 poll idle", d, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr(8'd1, 8'hF5);
        rdreg(8'd1, d); chk("R2 dir masked", d, 8'h05);
        wr(8'd2, 8'hFF);
        rdreg(8'd2, d); chk("R2 report bit0 only", d, 8'h01);
        wr(8'd2, 8'h00);
        wr(8'd1, 8'hFF);
        wr(8'd0, 8'h9C);
        rdreg(8'd0, d); chk("R2 level masked", d, 8'h0C);
    endtask

    task automatic t_ack;
        @(negedge clk);
        bus_stb = 1'b1; bus_addr = 8'd1;
        @(negedge clk);
        bus_stb = 1'b0;
        chk("R3 ack with strobe", {7'd0, bus_ack}, 8'd1);
        @(negedge clk);
        chk("R3 ack drops", {7'd0, bus_ack}, 8'd0);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(8'd0, 8'h06);
        wr(8'd1, 8'h0F);
        wr(8'd3, 8'hFF);
        wr(8'd5, 8'h00);
        chk("R4 oe unchanged", {4'd0, pin_oe}, 8'h0F);
        chk("R4 out unchanged", {4'd0, pin_out}, 8'h06);
        rdreg(8'd5, d);   chk("R4 unmapped read", d, 8'h00);
        rdreg(8'd255, d); chk("R4 top address read", d, 8'h00);
        rdreg(8'd2, d);   chk("R4 report untouched", d, 8'h00);
    endtask

    task automatic t_pins;
        wr(8'd0, 8'h0F);
        wr(8'd1, 8'h03);
        chk("R5 oe follows dir", {4'd0, pin_oe}, 8'h03);
        chk("R5 out on outputs only", {4'd0, pin_out}, 8'h03);
        wr(8'd0, 8'h0A);
        chk("R5 out after level write", {4'd0, pin_out}, 8'h02);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        wr(8'd0, 8'h05);
        wr(8'd1, 8'h03);
        @(negedge clk); pin_in = 4'b1010;
        repeat (3) @(negedge clk);
        rdreg(8'd0, d);
        chk("R6 mixed readback", d, {4'd0, (4'h5 & 4'h3) | (4'b1010 & ~4'h3)});
        wr(8'd1, 8'h00);
        rdreg(8'd0, d); chk("R6 all inputs", d, 8'h0A);
    endtask

    task automatic t_report;
        logic [7:0] d;
        wr(8'd1, 8'h00);
        repeat (4) @(negedge clk);
        poll(d);
        wr(8'd2, 8'h01);
        poll(d); chk("R7 nothing pending", d, 8'h00);
        @(negedge clk); pin_in = pin_in ^ 4'b0001;
        repeat (4) @(negedge clk);
        poll(d); chk("R7 change reported", d, 8'h03);
        poll(d); chk("R8 cleared by poll", d, 8'h00);
        @(negedge clk); pin_in = pin_in ^ 4'b1000;
        repeat (2) @(negedge clk);
        pin_in = pin_in ^ 4'b1000;
        repeat (5) @(negedge clk);
        poll(d); chk("R7 pulse latched", d, 8'h03);
        poll(d); chk("R8 cleared again", d, 8'h00);
    endtask

    task automatic t_silent;
        logic [7:0] d;
        wr(8'd2, 8'h00);
        @(negedge clk); pin_in = pin_in ^ 4'b0110;
        repeat (4) @(negedge clk);
        poll(d); chk("R9 disabled ignores change", d, 8'h00);
        wr(8'd1, 8'h04);
        wr(8'd2, 8'h01);
        @(negedge clk); pin_in = pin_in ^ 4'b0100;
        repeat (4) @(negedge clk);
        poll(d); chk("R9 output pin ignored", d, 8'h00);
        @(negedge clk); pin_in = pin_in ^ 4'b0010;
        repeat (4) @(negedge clk);
        poll(d); chk("R9 input pin still reports", d, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_ack;
        t_unmapped;
        t_pins;
        t_readback;
        t_report;
        t_silent;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule